// File: doc/BRIEF.md
# Video Line Clamp Timing Generator

This block produces the once-per-line clamp pulse that a video digitizer front end uses to restore black level on its AC-coupled inputs. It runs in the pixel clock domain. It watches a horizontal sync input through a two-flop synchronizer. When the sync pulse ends, it waits a programmable number of pixel clocks and then raises the clamp for a programmable number of pixel clocks. The pulse is timed from the end of sync, not its start. Sync width varies a great deal between video modes, while the black back porch always comes right after sync.

A bypass lets an external clamp strobe drive the output instead of the internal generator, with a selectable active level. The block also gives, for each colour channel, the code the restore loop should target. Red and blue can each choose bottom code 0x00 or midscale 0x80, which suits colour-difference signals. Green always targets 0x00. All settings arrive on plain parallel inputs. The delay and length are captured at each sync trailing edge.

Top module: `line_clamp_gen`

## Requirements
- R1: While rstN is low, and after reset until the first sync trailing edge, clampOut is 0.
- R2: In internal mode (useExtClamp=0), let n be the rising clock edge that first samples hsyncIn at its trailing level, and let D be startDelay and L be pulseLen. Then clampOut is 1 after edges n+2+D through n+1+D+L, and 0 after the edges just before and just after that run.
- R3: hsyncActiveHigh=1 makes a falling hsyncIn the trailing edge. hsyncActiveHigh=0 makes a rising hsyncIn the trailing edge. The leading edge never changes clampOut.
- R4: A pulseLen of 0 at the trailing edge produces no clamp pulse on that line.
- R5: A trailing edge that arrives while a delay or pulse is in progress clears clampOut and restarts the delay count, using the values present at the new edge.
- R6: startDelay and pulseLen are sampled only at the trailing edge. Changing them afterwards does not change the current line's pulse.
- R7: When useExtClamp=1, clampOut after each clock edge equals the extClampIn value sampled at that edge if extActiveHigh=1, and its inverse if extActiveHigh=0.
- R8: redTarget is 0x80 when redMidscale=1 and 0x00 otherwise. blueTarget follows blueMidscale the same way. greenTarget is always 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncIn | input | 1 | Raw horizontal sync, asynchronous |
| hsyncActiveHigh | input | 1 | 1: sync pulse is high; 0: sync pulse is low |
| startDelay | input | 8 | Pixel clocks from sync end to clamp start |
| pulseLen | input | 8 | Clamp length in pixel clocks; 0 disables |
| useExtClamp | input | 1 | 1: external clamp path; 0: internal generator |
| extClampIn | input | 1 | External clamp strobe |
| extActiveHigh | input | 1 | Active level of extClampIn |
| redMidscale | input | 1 | Red target select: 1 midscale, 0 bottom |
| blueMidscale | input | 1 | Blue target select: 1 midscale, 0 bottom |
| clampOut | output | 1 | Registered active-high clamp |
| redTarget | output | 8 | Red restore code |
| greenTarget | output | 8 | Green restore code |
| blueTarget | output | 8 | Blue restore code |

## Verification
A wrong count or a wrong phase decode shows up on clampOut within one line. It appears as a pulse that starts one or more clocks early or late, runs too long or too short, or never ends. A bad edge detector makes the pulse follow the sync leading edge, or makes it follow neither edge. Both are visible within D+L+3 clocks of the sync transition. Stale or early configuration capture shows up only when settings change mid-line, so the bench changes them inside the delay window. Target-code errors are visible at once on the combinational outputs.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_PULSE = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;   // capture settings from the inputs this cycle
    logic loadDelay;  // counter <- start delay
    logic loadPulse;  // counter <- pulse length
    logic countDown;  // counter decrements
    logic clampOn;    // internal clamp rises
    logic clampOff;   // internal clamp falls
  } strobe_t;

  // flags from datapath to control
  typedef struct packed {
    logic cntLast;     // counter holds 1
    logic inDelayZero; // startDelay input is 0
    logic inLenZero;   // pulseLen input is 0
    logic cfgLenZero;  // captured length is 0
  } status_t;

endpackage

// File: rtl/lcg_ctrl.sv
module lcg_ctrl
  import lcg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hsyncIn,
  input  logic    hsyncActiveHigh,
  input  status_t status,
  output strobe_t strobes
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic syncLevel;
  logic activeNow;
  logic activePrev;
  logic trailEdge;
  phase_e phase, phaseNext;

  // synchronizer chain
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= hsyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  assign syncLevel = syncChain[SYNC_STAGES-1];
  assign activeNow = hsyncActiveHigh ? syncLevel : ~syncLevel;
  assign trailEdge = activePrev & ~activeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePrev <= 1'b0;
      phase      <= PH_IDLE;
    end else begin
      activePrev <= activeNow;
      phase      <= phaseNext;
    end
  end

  always_comb begin
    strobes   = '0;
    phaseNext = phase;
    if (trailEdge) begin
      strobes.latchCfg = 1'b1;
      if (!status.inDelayZero) begin
        strobes.loadDelay = 1'b1;
        strobes.clampOff  = 1'b1;
        phaseNext         = PH_WAIT;
      end else if (!status.inLenZero) begin
        strobes.loadPulse = 1'b1;
        strobes.clampOn   = 1'b1;
        phaseNext         = PH_PULSE;
      end else begin
        strobes.clampOff = 1'b1;
        phaseNext        = PH_IDLE;
      end
    end else begin
      unique case (phase)
        PH_WAIT: begin
          if (status.cntLast) begin
            if (status.cfgLenZero) begin
              phaseNext = PH_IDLE;
            end else begin
              strobes.loadPulse = 1'b1;
              strobes.clampOn   = 1'b1;
              phaseNext         = PH_PULSE;
            end
          end else begin
            strobes.countDown = 1'b1;
          end
        end
        PH_PULSE: begin
          if (status.cntLast) begin
            strobes.clampOff = 1'b1;
            phaseNext        = PH_IDLE;
          end else begin
            strobes.countDown = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcg_datapath.sv
module lcg_datapath
  import lcg_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 8,
  parameter int DEF_LEN = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  startDelay,
  input  logic [CNT_W-1:0]  pulseLen,
  input  logic              useExtClamp,
  input  logic              extClampIn,
  input  logic              extActiveHigh,
  input  logic              redMidscale,
  input  logic              blueMidscale,
  input  strobe_t           strobes,
  output status_t           status,
  output logic              clampOut,
  output logic [DATA_W-1:0] redTarget,
  output logic [DATA_W-1:0] greenTarget,
  output logic [DATA_W-1:0] blueTarget
);

  localparam int NUM_CH = 3;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cfgLen;
  logic intClamp, intClampNext;
  logic extLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      cfgLen <= CNT_W'(DEF_LEN);
    end else begin
      if (strobes.latchCfg) cfgLen <= pulseLen;
      if (strobes.loadDelay)      cnt <= startDelay;
      else if (strobes.loadPulse) cnt <= strobes.latchCfg ? pulseLen : cfgLen;
      else if (strobes.countDown) cnt <= cnt - 1'b1;
    end
  end

  assign status.cntLast     = (cnt == CNT_W'(1));
  assign status.inDelayZero = (startDelay == '0);
  assign status.inLenZero   = (pulseLen == '0);
  assign status.cfgLenZero  = (cfgLen == '0);

  always_comb begin
    intClampNext = intClamp;
    if (strobes.clampOn)       intClampNext = 1'b1;
    else if (strobes.clampOff) intClampNext = 1'b0;
  end

  assign extLevel = (extClampIn == extActiveHigh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intClamp <= 1'b0;
      clampOut <= 1'b0;
    end else begin
      intClamp <= intClampNext;
      clampOut <= useExtClamp ? extLevel : intClampNext;
    end
  end

  // per-channel restore code; index 1 (green) has no midscale option
  logic [NUM_CH-1:0]  midSel;
  logic [DATA_W-1:0]  chCode [NUM_CH];
  assign midSel = {blueMidscale, 1'b0, redMidscale};

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_code
      assign chCode[ch] = midSel[ch] ? MID_CODE : '0;
    end
  endgenerate

  assign redTarget   = chCode[0];
  assign greenTarget = chCode[1];
  assign blueTarget  = chCode[2];

endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen
  import lcg_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_LEN     = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncIn,
  input  logic              hsyncActiveHigh,
  input  logic [CNT_W-1:0]  startDelay,
  input  logic [CNT_W-1:0]  pulseLen,
  input  logic              useExtClamp,
  input  logic              extClampIn,
  input  logic              extActiveHigh,
  input  logic              redMidscale,
  input  logic              blueMidscale,
  output logic              clampOut,
  output logic [DATA_W-1:0] redTarget,
  output logic [DATA_W-1:0] greenTarget,
  output logic [DATA_W-1:0] blueTarget
);

  strobe_t strobes;
  status_t status;

  lcg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .hsyncIn         (hsyncIn),
    .hsyncActiveHigh (hsyncActiveHigh),
    .status          (status),
    .strobes         (strobes)
  );

  lcg_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W), .DEF_LEN(DEF_LEN)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .startDelay    (startDelay),
    .pulseLen      (pulseLen),
    .useExtClamp   (useExtClamp),
    .extClampIn    (extClampIn),
    .extActiveHigh (extActiveHigh),
    .redMidscale   (redMidscale),
    .blueMidscale  (blueMidscale),
    .strobes       (strobes),
    .status        (status),
    .clampOut      (clampOut),
    .redTarget     (redTarget),
    .greenTarget   (greenTarget),
    .blueTarget    (blueTarget)
  );

endmodule

// File: rtl/lcg_checker.sv
module lcg_checker #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              useExtClamp,
  input logic              extClampIn,
  input logic              extActiveHigh,
  input logic              redMidscale,
  input logic              blueMidscale,
  input logic              clampOut,
  input logic [DATA_W-1:0] redTarget,
  input logic [DATA_W-1:0] greenTarget,
  input logic [DATA_W-1:0] blueTarget
);

  localparam int RUN_W = CNT_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'((1 << CNT_W) - 1);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  // consecutive internal-mode high cycles, saturating
  logic [RUN_W-1:0] highRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highRun <= '0;
    else if (!clampOut || useExtClamp) highRun <= '0;
    else if (highRun != '1) highRun <= highRun + 1'b1;
  end

  p_pulse_bounded_r2: assert property (@(posedge clk) disable iff (!rstN)
    highRun <= RUN_MAX);

  p_reset_low_r1: assert property (@(posedge clk)
    !rstN |=> (!rstN |-> !clampOut));

  p_ext_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(useExtClamp)) |->
      (clampOut == ($past(extClampIn) == $past(extActiveHigh))));

  p_green_ground_r8: assert property (@(posedge clk) disable iff (!rstN)
    greenTarget == '0);

  p_red_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    redTarget == (redMidscale ? MID : '0));

  p_blue_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    blueTarget == (blueMidscale ? MID : '0));

endmodule

bind line_clamp_gen lcg_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_lcg_checker (
  .clk           (clk),
  .rstN          (rstN),
  .useExtClamp   (useExtClamp),
  .extClampIn    (extClampIn),
  .extActiveHigh (extActiveHigh),
  .redMidscale   (redMidscale),
  .blueMidscale  (blueMidscale),
  .clampOut      (clampOut),
  .redTarget     (redTarget),
  .greenTarget   (greenTarget),
  .blueTarget    (blueTarget)
);

// File: tb/test_line_clamp_gen.sv
`timescale 1ns/1ps
module test_line_clamp_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncIn = 1'b0;
  logic       hsyncActiveHigh = 1'b1;
  logic [7:0] startDelay = 8'd8;
  logic [7:0] pulseLen = 8'd20;
  logic       useExtClamp = 1'b0;
  logic       extClampIn = 1'b0;
  logic       extActiveHigh = 1'b1;
  logic       redMidscale = 1'b0;
  logic       blueMidscale = 1'b0;
  logic       clampOut;
  logic [7:0] redTarget, greenTarget, blueTarget;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  line_clamp_gen i_line_clamp_gen (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .hsyncActiveHigh(hsyncActiveHigh),
    .startDelay(startDelay), .pulseLen(pulseLen), .useExtClamp(useExtClamp),
    .extClampIn(extClampIn), .extActiveHigh(extActiveHigh),
    .redMidscale(redMidscale), .blueMidscale(blueMidscale),
    .clampOut(clampOut), .redTarget(redTarget), .greenTarget(greenTarget),
    .blueTarget(blueTarget)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // leading edge, then trailing edge; checks the clamp each cycle
  // chgAt >= 0: new settings applied after that cycle (R6)
  task automatic runLine(input int d, input int l, input bit pol, input int chgAt);
    @(negedge clk);
    hsyncActiveHigh = pol;
    hsyncIn = pol;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      check(clampOut == 1'b0, "R3 leading edge", clampOut, 0);
    end
    @(negedge clk);
    startDelay = 8'(d);
    pulseLen = 8'(l);
    hsyncIn = ~pol;
    for (int k = 0; k < d + l + 6; k++) begin
      @(posedge clk); #1;
      if (k >= 2 + d && k < 2 + d + l)
        check(clampOut == 1'b1, (chgAt >= 0) ? "R6 high" : "R2 high", clampOut, 1);
      else
        check(clampOut == 1'b0, (l == 0) ? "R4 no pulse" : "R2 low", clampOut, 0);
      if (k == chgAt) begin
        @(negedge clk);
        startDelay = 8'd0;
        pulseLen = 8'd60;
      end
    end
  endtask

  initial begin
    int dl [6] = '{0, 1, 2, 3, 7, 8};
    int ll [4] = '{0, 1, 3, 20};
    #1;
    check(clampOut == 1'b0, "R1 in reset", clampOut, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    repeat (4) @(posedge clk);
    #1 check(clampOut == 1'b0, "R1 after reset", clampOut, 0);

    // R2 R3 R4 sweep over delay, length and sync polarity
    for (int p = 0; p < 2; p++)
      foreach (dl[i])
        foreach (ll[j])
          runLine(dl[i], ll[j], p[0], -1);

    // R6: settings change during the delay window
    runLine(3, 4, 1'b1, 3);
    runLine(0, 0, 1'b1, -1);

    // R5: second trailing edge during the pulse (D=5, L=10)
    @(negedge clk);
    hsyncActiveHigh = 1'b1;
    startDelay = 8'd5; pulseLen = 8'd10;
    hsyncIn = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); hsyncIn = 1'b0;
    for (int k = 0; k < 31; k++) begin
      bit exp;
      @(posedge clk); #1;
      exp = (k >= 7 && k < 12) || (k >= 17 && k < 27);
      check(clampOut == exp, "R5 retrigger", clampOut, exp);
      if (k == 8)  begin @(negedge clk); hsyncIn = 1'b1; end
      if (k == 9)  begin @(negedge clk); hsyncIn = 1'b0; end
    end

    // R7: external path, every level and polarity
    @(negedge clk); useExtClamp = 1'b1;
    for (int pol = 0; pol < 2; pol++)
      for (int lv = 0; lv < 2; lv++)
        for (int rep = 0; rep < 2; rep++) begin
          bit exp;
          @(negedge clk);
          extActiveHigh = pol[0];
          extClampIn = lv[0];
          exp = (lv == pol);
          @(posedge clk); #1;
          check(clampOut == exp, "R7 external", clampOut, exp);
        end
    @(negedge clk); useExtClamp = 1'b0;

    // R8: restore codes
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      redMidscale = m[0];
      blueMidscale = m[1];
      #1;
      check(redTarget == (m[0] ? 8'h80 : 8'h00), "R8 red", redTarget, m[0] ? 128 : 0);
      check(blueTarget == (m[1] ? 8'h80 : 8'h00), "R8 blue", blueTarget, m[1] ? 128 : 0);
      check(greenTarget == 8'h00, "R8 green", greenTarget, 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule